// File: doc/BRIEF.md
# Data Access Trace Range Filter

This block watches the processor's data accesses and decides, separately for each of two trace channels, whether an access should produce a trace message. Every channel has an address window, given by an inclusive lower bound and an inclusive upper bound. It also has a two-bit direction enable that selects whether reads, writes or both are of interest. A per-channel watchpoint flag makes a matching access raise a second pulse as well, which the debug logic can use to halt or flag the processor.

All bounds, direction enables and watchpoint flags sit in a small register file behind a simple write strobe and an address. Read data comes back combinationally. Each clock the block samples an access strobe, the access address and a write flag. One clock later it drives one match bit and one watchpoint bit per channel.

The access side is an observation port with a valid strobe and no ready. The block accepts one access on every clock in which the strobe is high, and it never applies back-pressure to the bus it monitors. Message building and packetizing belong to the logic downstream of the match outputs.

Top module: `dtrace_filter`

## Requirements
- R1: After reset every register reads zero. The control word is at register address 0. Channel 0's lower and upper bounds are at addresses 1 and 2, and channel 1's are at 3 and 4. Every other address reads zero and ignores writes. A written bound reads back exactly.
- R2: A channel matches an access when lower <= address <= upper, and both bounds are included.
- R3: When a channel's lower bound equals its upper bound, the channel matches that single address and no other.
- R4: When a channel's lower bound exceeds its upper bound, the channel never matches.
- R5: A read access (write flag low) can match channel n only when the read-enable bit is set. That bit is control bit 30 for channel 0 and bit 28 for channel 1. A field value of 00 disables the channel.
- R6: A write access (write flag high) can match channel n only when the write-enable bit is set. That bit is control bit 31 for channel 0 and bit 29 for channel 1. The value 11 enables both directions.
- R7: The watchpoint output of channel n pulses together with its match output only when the channel's watchpoint bit is set. That bit is control bit 0 for channel 0 and bit 1 for channel 1. With the bit clear, the watchpoint output stays low.
- R8: The match and watchpoint outputs are registered and appear exactly one clock after the access strobe is sampled. They are low in any cycle that follows a cycle with the strobe low, whatever the address.
- R9: Control bits 27:2 always read zero, and writes to them are ignored. An all-ones write therefore reads back as 0xF0000003.
- R10: The address compare is unsigned over all 32 bits, so an address with bit 31 set lies above every address with bit 31 clear.
- R11: A register write takes effect for accesses sampled at later clock edges. An access sampled on the same edge as the write is judged against the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| acc_valid | input | 1 | Data access strobe, always accepted |
| acc_addr | input | 32 | Data access address |
| acc_write | input | 1 | 1 for a write access, 0 for a read |
| hit | output | 2 | Per-channel trace match pulse, bit n for channel n |
| wpt | output | 2 | Per-channel watchpoint pulse, bit n for channel n |

## Verification
A corrupted bound shows up on the `hit` bit of the first access that falls between the true bound and the corrupted one. It appears one clock after that access, and it is also visible at once on a read of the bound's register. A wrong direction enable or watchpoint bit shows up as a missing or extra pulse on the very next access of that direction to the window, and as a wrong read of the control word. Probing addresses just inside and just outside each bound, and the top of the 32-bit space, exposes off-by-one and signed-compare faults within one access.

// File: rtl/dtrace_pkg.sv
package dtrace_pkg;

  // Direction enable of one channel: upper bit writes, lower bit reads.
  typedef struct packed {
    logic wr;
    logic rd;
  } rw_en_t;

  localparam int unsigned RA_W = 3;
  localparam logic [RA_W-1:0] RA_CTRL = '0;

  // Register address of the lower bound of channel n; the upper bound follows it.
  function automatic logic [RA_W-1:0] ra_lo(input int n);
    return RA_W'(2 * n + 1);
  endfunction

  function automatic logic [RA_W-1:0] ra_hi(input int n);
    return RA_W'(2 * n + 2);
  endfunction

endpackage

// File: rtl/dtrace_regs.sv
module dtrace_regs
  import dtrace_pkg::*;
#(
  parameter int AW  = 32,
  parameter int NCH = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic [RA_W-1:0]         reg_addr,
  input  logic [AW-1:0]           reg_wdata,
  output logic [AW-1:0]           reg_rdata,
  output logic [NCH-1:0][AW-1:0]  lo_o,
  output logic [NCH-1:0][AW-1:0]  hi_o,
  output rw_en_t [NCH-1:0]        en_o,
  output logic [NCH-1:0]          wp_o
);

  // Only the live control bits are stored; reserved bits have no flops.
  localparam int RSV_HI = AW - 2 * NCH - 1;
  localparam int RSV_LO = NCH;

  logic [NCH-1:0][AW-1:0] lo_q, hi_q;
  rw_en_t [NCH-1:0]       en_q;
  logic [NCH-1:0]         wp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
      en_q <= '0;
      wp_q <= '0;
    end else if (reg_wr) begin
      for (int n = 0; n < NCH; n++) begin
        if (reg_addr == RA_CTRL) begin
          en_q[n] <= rw_en_t'(reg_wdata[AW-1-2*n -: 2]);
          wp_q[n] <= reg_wdata[n];
        end
        if (reg_addr == ra_lo(n)) lo_q[n] <= reg_wdata;
        if (reg_addr == ra_hi(n)) hi_q[n] <= reg_wdata;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int n = 0; n < NCH; n++) begin
      if (reg_addr == RA_CTRL) begin
        reg_rdata[AW-1-2*n -: 2] = en_q[n];
        reg_rdata[n]             = wp_q[n];
      end
      if (reg_addr == ra_lo(n)) reg_rdata = lo_q[n];
      if (reg_addr == ra_hi(n)) reg_rdata = hi_q[n];
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;
  assign en_o = en_q;
  assign wp_o = wp_q;

  // R9: reserved control bits never read back as one.
  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == RA_CTRL) |-> (reg_rdata[RSV_HI:RSV_LO] == '0));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R1: a written bound is held exactly.
    a_r1_lo_written: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ra_lo(g)) |=> (lo_o[g] == $past(reg_wdata)));
    a_r1_hi_written: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ra_hi(g)) |=> (hi_o[g] == $past(reg_wdata)));
  end

endmodule

// File: rtl/dtrace_chan.sv
module dtrace_chan
  import dtrace_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_write,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  rw_en_t        en,
  input  logic          wp,
  output logic          hit_o,
  output logic          wpt_o
);

  logic above_lo, below_hi, dir_ok, take;

  // Two independent unsigned compares; an inverted window fails one of them.
  assign above_lo = (acc_addr >= lo);
  assign below_hi = (acc_addr <= hi);
  assign dir_ok   = acc_write ? en.wr : en.rd;
  assign take     = acc_valid && above_lo && below_hi && dir_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_o <= 1'b0;
      wpt_o <= 1'b0;
    end else begin
      hit_o <= take;
      wpt_o <= take && wp;
    end
  end

  // R8: no output one cycle after an idle strobe.
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (!hit_o && !wpt_o));

  // R2: an address outside the window never matches.
  a_r2_outside_window: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (acc_addr < lo || acc_addr > hi)) |=> !hit_o);

  // R4: an inverted window never matches.
  a_r4_inverted_window: assert property (@(posedge clk) disable iff (!rst_n)
    (lo > hi) |=> !hit_o);

  // R5: a read needs the read enable.
  a_r5_read_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && !en.rd) |=> !hit_o);

  // R6: a write needs the write enable.
  a_r6_write_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && !en.wr) |=> !hit_o);

  // R7: a watchpoint pulse only accompanies a match with the flag set.
  a_r7_wpt_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    wpt_o |-> hit_o);
  a_r7_wpt_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !wp |=> !wpt_o);

endmodule

// File: rtl/dtrace_filter.sv
module dtrace_filter
  import dtrace_pkg::*;
#(
  parameter int AW  = 32,
  parameter int NCH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [AW-1:0]   reg_wdata,
  output logic [AW-1:0]   reg_rdata,
  input  logic            acc_valid,
  input  logic [AW-1:0]   acc_addr,
  input  logic            acc_write,
  output logic [NCH-1:0]  hit,
  output logic [NCH-1:0]  wpt
);

  logic [NCH-1:0][AW-1:0] lo, hi;
  rw_en_t [NCH-1:0]       en;
  logic [NCH-1:0]         wp;

  dtrace_regs #(.AW(AW), .NCH(NCH)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .lo_o      (lo),
    .hi_o      (hi),
    .en_o      (en),
    .wp_o      (wp)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    dtrace_chan #(.AW(AW)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_valid (acc_valid),
      .acc_addr  (acc_addr),
      .acc_write (acc_write),
      .lo        (lo[g]),
      .hi        (hi[g]),
      .en        (en[g]),
      .wp        (wp[g]),
      .hit_o     (hit[g]),
      .wpt_o     (wpt[g])
    );
  end

endmodule

// File: tb/dtrace_filter_bench.sv
module dtrace_filter_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic [1:0]  hit, wpt;

  always #2 clk = ~clk;

  dtrace_filter u_dtrace_filter (
    .clk (clk), .rst_n (rst_n),
    .reg_wr (reg_wr), .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
    .acc_valid (acc_valid), .acc_addr (acc_addr), .acc_write (acc_write),
    .hit (hit), .wpt (wpt)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Shadow of the registers, built from the requirements.
  logic [31:0] sh_ctrl = '0;
  logic [31:0] sh_lo [2] = '{default: '0};
  logic [31:0] sh_hi [2] = '{default: '0};

  typedef struct {
    logic [1:0] h;
    logic [1:0] w;
    string      tag;
  } exp_t;
  exp_t q[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t predict(input logic [31:0] a, input logic wr, input string tag);
    exp_t e;
    for (int n = 0; n < 2; n++) begin
      logic [1:0] en;
      en = sh_ctrl[31-2*n -: 2];
      e.h[n] = (sh_lo[n] <= a) && (a <= sh_hi[n]) && (wr ? en[1] : en[0]);
      e.w[n] = e.h[n] && sh_ctrl[n];
    end
    e.tag = tag;
    return e;
  endfunction

  function automatic void shadow_write(input logic [2:0] ra, input logic [31:0] d);
    case (ra)
      3'd0: sh_ctrl = d & 32'hF000_0003;
      3'd1: sh_lo[0] = d;
      3'd2: sh_hi[0] = d;
      3'd3: sh_lo[1] = d;
      3'd4: sh_hi[1] = d;
      default: ;
    endcase
  endfunction

  task automatic reg_write(input logic [2:0] ra, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = ra; reg_wdata = d;
    @(posedge clk);
    shadow_write(ra, d);
    #1 reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] ra, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = ra;
    #1 chk(tag, reg_rdata, exp);
  endtask

  task automatic access(input logic [31:0] a, input logic wr, input string tag);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_write = wr;
    q.push_back(predict(a, wr, tag));
    @(posedge clk);
    #1 acc_valid = 1'b0;
  endtask

  // R11: write and access on the same edge; expectation uses old contents.
  task automatic write_with_access(input logic [2:0] ra, input logic [31:0] d,
                                   input logic [31:0] a, input logic wr, input string tag);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = ra; reg_wdata = d;
    acc_valid = 1'b1; acc_addr = a; acc_write = wr;
    q.push_back(predict(a, wr, tag));
    @(posedge clk);
    shadow_write(ra, d);
    #1 begin reg_wr = 1'b0; acc_valid = 1'b0; end
  endtask

  // Monitor: one clock after a sampled strobe, pop and compare; otherwise expect silence (R8).
  logic sent = 1'b0;
  always @(posedge clk) sent <= acc_valid;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (sent) begin
        if (q.size() == 0) begin
          chk("R8 output without queued access", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(e.tag, {28'd0, hit, wpt}, {28'd0, e.h, e.w});
        end
      end else begin
        chk("R8 idle cycle outputs", {28'd0, hit, wpt}, 32'd0);
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset values, including unmapped addresses
    for (int i = 0; i < 8; i++) reg_read(3'(i), 32'd0, "R1 reset read");
    chk("R1 reset outputs", {28'd0, hit, wpt}, 32'd0);

    // R1 readback, R9 reserved bits
    reg_write(3'd1, 32'h0000_0100);
    reg_write(3'd2, 32'h0000_01FF);
    reg_read(3'd1, 32'h0000_0100, "R1 lower bound readback");
    reg_read(3'd2, 32'h0000_01FF, "R1 upper bound readback");
    reg_write(3'd6, 32'hDEAD_BEEF);
    reg_read(3'd6, 32'd0, "R1 unmapped address reads zero");
    reg_write(3'd0, 32'hFFFF_FFFF);
    reg_read(3'd0, 32'hF000_0003, "R9 reserved bits read zero");

    // R2: inclusive window on channel 0, reads only
    reg_write(3'd0, 32'h4000_0000);
    access(32'h0000_00FF, 1'b0, "R2 below lower bound");
    access(32'h0000_0100, 1'b0, "R2 at lower bound");
    access(32'h0000_0150, 1'b0, "R2 inside window");
    access(32'h0000_01FF, 1'b0, "R2 at upper bound");
    access(32'h0000_0200, 1'b0, "R2 above upper bound");
    access(32'h0000_0150, 1'b1, "R6 write with write enable off");

    // R3: single address on channel 1
    reg_write(3'd3, 32'h0000_4000);
    reg_write(3'd4, 32'h0000_4000);
    reg_write(3'd0, 32'h5000_0000);
    access(32'h0000_3FFF, 1'b0, "R3 one below single address");
    access(32'h0000_4000, 1'b0, "R3 single address");
    access(32'h0000_4001, 1'b0, "R3 one above single address");

    // R5 / R6: direction enables
    reg_write(3'd0, 32'hA000_0000);
    access(32'h0000_0150, 1'b1, "R6 write enabled channel 0");
    access(32'h0000_0150, 1'b0, "R5 read with read enable off");
    access(32'h0000_4000, 1'b1, "R6 write enabled channel 1");
    reg_write(3'd0, 32'hF000_0000);
    access(32'h0000_4000, 1'b0, "R6 both enabled read");
    access(32'h0000_4000, 1'b1, "R6 both enabled write");
    reg_write(3'd0, 32'h0000_0000);
    access(32'h0000_0150, 1'b0, "R5 disabled read");
    access(32'h0000_0150, 1'b1, "R5 disabled write");

    // R7: watchpoints
    reg_write(3'd0, 32'hF000_0001);
    access(32'h0000_0150, 1'b0, "R7 channel 0 watchpoint set");
    access(32'h0000_4000, 1'b0, "R7 channel 1 watchpoint clear");
    reg_write(3'd0, 32'hF000_0002);
    access(32'h0000_4000, 1'b1, "R7 channel 1 watchpoint set");
    reg_write(3'd3, 32'h0000_0180);
    reg_write(3'd0, 32'hF000_0003);
    access(32'h0000_01A0, 1'b0, "R7 overlapping windows both watchpoints");
    access(32'h0000_0100, 1'b1, "R7 channel 0 only in overlap setup");

    // R4: inverted window
    reg_write(3'd1, 32'h0000_0300);
    reg_write(3'd2, 32'h0000_0200);
    access(32'h0000_0250, 1'b0, "R4 inverted window middle");
    access(32'h0000_0200, 1'b0, "R4 inverted window upper value");
    access(32'h0000_0300, 1'b1, "R4 inverted window lower value");

    // R8: strobe low with an in-range address
    @(negedge clk);
    acc_valid = 1'b0; acc_addr = 32'h0000_0200; acc_write = 1'b0;
    repeat (4) @(posedge clk);

    // R10: unsigned compare across bit 31 and at the top of the space
    reg_write(3'd1, 32'h7FFF_FFF0);
    reg_write(3'd2, 32'h8000_0010);
    reg_write(3'd3, 32'hFFFF_FFF0);
    reg_write(3'd4, 32'hFFFF_FFFF);
    access(32'h8000_0000, 1'b0, "R10 window spanning bit 31");
    access(32'h0000_0005, 1'b0, "R10 small address below window");
    access(32'hFFFF_FFFF, 1'b1, "R10 top address");
    access(32'hFFFF_FFEF, 1'b0, "R10 just below top window");

    // R11: same-edge write uses old contents, next access uses new
    write_with_access(3'd0, 32'h0000_0000, 32'h8000_0000, 1'b0, "R11 access on write edge");
    access(32'h8000_0000, 1'b0, "R11 access after write");
    reg_read(3'd0, 32'd0, "R11 control readback after write");

    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk("R8 scoreboard drained", q.size(), 32'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule